// File: doc/BRIEF.md
# Core thread quiesce controller

The block lets one hardware thread in a multithreaded core stop all the other threads and later let them go again. It is used for work that has to touch state shared by the whole core, such as a cache flush, without interference from the other threads. A request arrives already decoded. It carries an operation (quiesce-others or release-others), the issuing thread number, a destination register index, and three qualifiers: coprocessor-0 access allowed, speculative, and oldest-unretired.

A quiesce request stops fetch on every thread except the issuer and pulses a cancel line for the speculative work of those threads, such as prefetch and table walks. It then stalls retirement until those threads report no outstanding instructions. Only at that point does it set the core-wide quiesced flag and return the old control word through a register write-back port. A release request clears the flag and the held set in one edge.

While a thread is held, its interrupts are masked at the output without changing its stored enable. A thread parked in WAIT or PAUSE is not woken until the release comes. An external per-thread fetch enable is ANDed with the held state, so neither control can override the other.

Top module: `thread_quiesce_ctrl`

## Requirements
- R1: A quiesce (req_op=0) that is accepted at edge E drives fetch_en low from E on for every thread other than req_tid. At E, kill_spec pulses high for one cycle with exactly those threads set.
- R2: retire_stall is high combinationally in the cycle a quiesce is accepted. It stays high through the first cycle in which every held thread shows thr_busy=0, and is low after that. The busy bit of the issuing thread is ignored.
- R3: quiesced rises on the edge that ends the drain. On that same edge wb_en pulses for one cycle with wb_idx equal to the request's destination index and wb_data equal to the prior control word sign-extended. The control word has the quiesced flag at bit 0 and all other bits 0, so wb_data is 0. There is no pulse when the destination index is 0.
- R4: A quiesce that arrives while quiesced=1 changes nothing. There is no write-back, no stall, no cancel pulse and no change to fetch_en.
- R5: A release (req_op=1) clears quiesced and the held set on the next edge, and fetch returns on all threads.
- R6: fetch_en[i] = ext_fetch_en[i] AND NOT held[i]. A held thread does not fetch when its external enable rises, and a release does not restart a thread whose external enable is low.
- R7: eff_irq_en[i] = thr_ie[i] AND NOT held[i]. The issuer stays interruptible, and thr_ie is an input that the block never changes.
- R8: wake[i] is (thr_wait AND thr_irq AND thr_ie) OR (thr_pause AND NOT thr_link), gated to 0 while thread i is held. A release that arrives before the interrupt or the link clear leaves wake at 0.
- R9: A request with req_spec=1 or req_oldest=0, or one that arrives while a drain is in progress, has no effect and raises no exception.
- R10: A live request with req_cp0_ok=0 pulses exc_cpu for one cycle on the next edge and has no other effect.
- R11: With cfg_mt_en=0, a live request that has coprocessor access has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_mt_en | input | 1 | Multithreading support enabled |
| req_valid | input | 1 | Request present this cycle |
| req_op | input | 1 | 0 = quiesce others, 1 = release others |
| req_tid | input | TIDW | Issuing thread |
| req_dst | input | RIDX | Destination register index |
| req_cp0_ok | input | 1 | Coprocessor-0 access enabled |
| req_spec | input | 1 | Request is speculative |
| req_oldest | input | 1 | Request is oldest unretired |
| thr_busy | input | NTHR | Thread has outstanding instructions |
| thr_wait | input | NTHR | Thread parked in WAIT |
| thr_pause | input | NTHR | Thread parked in PAUSE |
| thr_link | input | NTHR | Thread link bit |
| thr_irq | input | NTHR | Pending interrupt per thread |
| thr_ie | input | NTHR | Stored interrupt enable per thread |
| ext_fetch_en | input | NTHR | External fetch enable per thread |
| fetch_en | output | NTHR | Fetch permitted per thread |
| eff_irq_en | output | NTHR | Effective interrupt enable per thread |
| wake | output | NTHR | Parked thread may resume |
| kill_spec | output | NTHR | Cancel prefetch and table walks |
| retire_stall | output | 1 | Hold retirement of the quiesce |
| wb_en | output | 1 | Register write-back strobe |
| wb_idx | output | RIDX | Write-back register index |
| wb_data | output | XLEN | Write-back value |
| exc_cpu | output | 1 | Coprocessor-unusable exception |
| quiesced | output | 1 | Core-wide quiesced flag |

## Verification
The bench sweeps every issuing thread and checks that the issuer keeps fetching and that the other threads stop. A design that masked the wrong thread, or that waited on the issuer's own busy bit, would deadlock or would let a neighbour run. Busy is held for several cycles and then dropped, so a flag set early, or a write-back that fires before the drain ends, is caught. The no-op cases are the nested quiesce, the speculative or non-oldest request, the configuration with multithreading off, and the request without coprocessor access. In each of them a design with a missing guard would raise the flag, write back, or fail to raise the exception. The WAIT, PAUSE and external-enable cases catch a held thread that is woken too early, or one that is restarted by the wrong one of the two fetch controls.

// File: rtl/qc_pkg.sv
// Shared types for the thread quiesce controller.
// Assumes: at most 2**TIDW threads; op encoding fixed at 1 bit.
package qc_pkg;
    typedef enum logic {
        OP_QUIESCE = 1'b0,
        OP_RELEASE = 1'b1
    } qc_op_e;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_DRAIN = 1'b1
    } qc_state_e;
endpackage

// File: rtl/qc_req_filter.sv
// Classifies one decoded request into quiesce, release or exception.
// Assumes: the request is valid for one cycle only; a drain in progress
// blocks any new request (the issuer is stalled anyway).
module qc_req_filter
    import qc_pkg::*;
(
    input  logic req_valid,
    input  logic req_op,
    input  logic req_cp0_ok,
    input  logic req_spec,
    input  logic req_oldest,
    input  logic cfg_mt_en,
    input  logic draining,
    input  logic quiesced,
    output logic quiesce_go,
    output logic release_go,
    output logic exc_go
);
    logic live;
    logic allowed;

    // Work out which action, if any, the request takes this cycle.
    always_comb begin
        live       = req_valid && !req_spec && req_oldest && !draining;
        allowed    = live && req_cp0_ok && cfg_mt_en;
        exc_go     = live && !req_cp0_ok;
        quiesce_go = allowed && (qc_op_e'(req_op) == OP_QUIESCE) && !quiesced;
        release_go = allowed && (qc_op_e'(req_op) == OP_RELEASE);
    end
endmodule

// File: rtl/qc_drain_fsm.sv
// Holds the quiesced flag, the held-thread set and the drain sequence.
// Assumes: quiesce_go and release_go are never high together and only in
// the idle state; the control word carries the quiesced flag at bit 0.
module qc_drain_fsm
    import qc_pkg::*;
#(
    parameter int NTHR = 4,
    parameter int TIDW = 2,
    parameter int RIDX = 5,
    parameter int XLEN = 64,
    parameter int CTLW = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            quiesce_go,
    input  logic            release_go,
    input  logic            exc_go,
    input  logic [TIDW-1:0] req_tid,
    input  logic [RIDX-1:0] req_dst,
    input  logic [NTHR-1:0] thr_busy,
    output logic [NTHR-1:0] held,
    output logic [NTHR-1:0] kill_spec,
    output logic            draining,
    output logic            quiesced,
    output logic            wb_en,
    output logic [RIDX-1:0] wb_idx,
    output logic [XLEN-1:0] wb_data,
    output logic            exc_cpu
);
    qc_state_e       st;
    logic [RIDX-1:0] dst_q;
    logic [NTHR-1:0] others;
    logic [CTLW-1:0] ctl_word;
    logic            drained;

    // Mask of every thread except the issuer; drain done test.
    always_comb begin
        others  = '1;
        others[req_tid] = 1'b0;
        drained = (thr_busy & held) == '0;
        ctl_word = '0;
        ctl_word[0] = quiesced;
    end

    assign draining = (st == ST_DRAIN);

    // Sequence: accept, wait for held threads to drain, then commit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st        <= ST_IDLE;
            held      <= '0;
            kill_spec <= '0;
            quiesced  <= 1'b0;
            dst_q     <= '0;
            wb_en     <= 1'b0;
            wb_idx    <= '0;
            wb_data   <= '0;
            exc_cpu   <= 1'b0;
        end else begin
            wb_en     <= 1'b0;
            kill_spec <= '0;
            exc_cpu   <= exc_go;
            case (st)
                ST_IDLE: begin
                    if (quiesce_go) begin
                        held      <= others;
                        kill_spec <= others;
                        dst_q     <= req_dst;
                        st        <= ST_DRAIN;
                    end else if (release_go) begin
                        held     <= '0;
                        quiesced <= 1'b0;
                    end
                end
                ST_DRAIN: begin
                    if (drained) begin
                        quiesced <= 1'b1;
                        wb_en    <= (dst_q != '0);
                        wb_idx   <= dst_q;
                        wb_data  <= {{(XLEN-CTLW){ctl_word[CTLW-1]}}, ctl_word};
                        st       <= ST_IDLE;
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/qc_thread_gate.sv
// Per-thread gating of fetch, interrupt enable and resume from WAIT/PAUSE.
// Assumes: held is a registered set; all outputs are combinational.
module qc_thread_gate #(
    parameter int NTHR = 4
) (
    input  logic [NTHR-1:0] held,
    input  logic [NTHR-1:0] ext_fetch_en,
    input  logic [NTHR-1:0] thr_ie,
    input  logic [NTHR-1:0] thr_wait,
    input  logic [NTHR-1:0] thr_irq,
    input  logic [NTHR-1:0] thr_pause,
    input  logic [NTHR-1:0] thr_link,
    output logic [NTHR-1:0] fetch_en,
    output logic [NTHR-1:0] eff_irq_en,
    output logic [NTHR-1:0] wake
);
    for (genvar g = 0; g < NTHR; g++) begin : g_thr
        logic wait_rdy;
        logic pause_rdy;
        // Combine both fetch controls and mask a held thread's interrupts.
        always_comb begin
            wait_rdy      = thr_wait[g] && thr_irq[g] && thr_ie[g];
            pause_rdy     = thr_pause[g] && !thr_link[g];
            fetch_en[g]   = ext_fetch_en[g] && !held[g];
            eff_irq_en[g] = thr_ie[g] && !held[g];
            wake[g]       = (wait_rdy || pause_rdy) && !held[g];
        end
    end
endmodule

// File: rtl/thread_quiesce_ctrl.sv
// Top of the thread quiesce controller: filters requests, runs the drain
// sequence and gates per-thread fetch, interrupts and wake-up.
// Assumes: NTHR >= 2; the request fields are stable while req_valid is high.
module thread_quiesce_ctrl #(
    parameter int NTHR = 4,
    parameter int TIDW = (NTHR > 1) ? $clog2(NTHR) : 1,
    parameter int RIDX = 5,
    parameter int XLEN = 64
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cfg_mt_en,
    input  logic            req_valid,
    input  logic            req_op,
    input  logic [TIDW-1:0] req_tid,
    input  logic [RIDX-1:0] req_dst,
    input  logic            req_cp0_ok,
    input  logic            req_spec,
    input  logic            req_oldest,
    input  logic [NTHR-1:0] thr_busy,
    input  logic [NTHR-1:0] thr_wait,
    input  logic [NTHR-1:0] thr_pause,
    input  logic [NTHR-1:0] thr_link,
    input  logic [NTHR-1:0] thr_irq,
    input  logic [NTHR-1:0] thr_ie,
    input  logic [NTHR-1:0] ext_fetch_en,
    output logic [NTHR-1:0] fetch_en,
    output logic [NTHR-1:0] eff_irq_en,
    output logic [NTHR-1:0] wake,
    output logic [NTHR-1:0] kill_spec,
    output logic            retire_stall,
    output logic            wb_en,
    output logic [RIDX-1:0] wb_idx,
    output logic [XLEN-1:0] wb_data,
    output logic            exc_cpu,
    output logic            quiesced
);
    localparam int CTLW = (XLEN < 32) ? XLEN : 32;

    logic            quiesce_go;
    logic            release_go;
    logic            exc_go;
    logic            draining;
    logic [NTHR-1:0] held;

    qc_req_filter u_filt (
        .req_valid  (req_valid),
        .req_op     (req_op),
        .req_cp0_ok (req_cp0_ok),
        .req_spec   (req_spec),
        .req_oldest (req_oldest),
        .cfg_mt_en  (cfg_mt_en),
        .draining   (draining),
        .quiesced   (quiesced),
        .quiesce_go (quiesce_go),
        .release_go (release_go),
        .exc_go     (exc_go)
    );

    qc_drain_fsm #(
        .NTHR(NTHR), .TIDW(TIDW), .RIDX(RIDX), .XLEN(XLEN), .CTLW(CTLW)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .quiesce_go (quiesce_go),
        .release_go (release_go),
        .exc_go     (exc_go),
        .req_tid    (req_tid),
        .req_dst    (req_dst),
        .thr_busy   (thr_busy),
        .held       (held),
        .kill_spec  (kill_spec),
        .draining   (draining),
        .quiesced   (quiesced),
        .wb_en      (wb_en),
        .wb_idx     (wb_idx),
        .wb_data    (wb_data),
        .exc_cpu    (exc_cpu)
    );

    qc_thread_gate #(.NTHR(NTHR)) u_gate (
        .held         (held),
        .ext_fetch_en (ext_fetch_en),
        .thr_ie       (thr_ie),
        .thr_wait     (thr_wait),
        .thr_irq      (thr_irq),
        .thr_pause    (thr_pause),
        .thr_link     (thr_link),
        .fetch_en     (fetch_en),
        .eff_irq_en   (eff_irq_en),
        .wake         (wake)
    );

    // Stall retirement in the accept cycle and for the whole drain.
    assign retire_stall = quiesce_go || draining;
endmodule

// File: rtl/qc_chk.sv
// Checker for the thread quiesce controller, bound to its top.
// Assumes: sampled at the rising clock edge, disabled during reset.
module qc_chk #(
    parameter int NTHR = 4,
    parameter int RIDX = 5
) (
    input logic            clk,
    input logic            rst_n,
    input logic            req_valid,
    input logic            req_spec,
    input logic [NTHR-1:0] fetch_en,
    input logic [NTHR-1:0] ext_fetch_en,
    input logic [NTHR-1:0] eff_irq_en,
    input logic [NTHR-1:0] thr_ie,
    input logic [NTHR-1:0] wake,
    input logic [NTHR-1:0] thr_wait,
    input logic [NTHR-1:0] thr_pause,
    input logic            retire_stall,
    input logic            wb_en,
    input logic [RIDX-1:0] wb_idx,
    input logic            exc_cpu,
    input logic            quiesced
);
    // R6
    fetch_subset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_en & ~ext_fetch_en) == '0);

    // R7
    irq_subset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (eff_irq_en & ~thr_ie) == '0);

    // R8
    wake_parked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wake & ~(thr_wait | thr_pause)) == '0);

    // R3
    wb_on_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wb_en |-> ($rose(quiesced) && wb_idx != '0));

    // R2
    flag_after_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(quiesced) |-> $past(retire_stall));

    // R10
    exc_alone_chk: assert property (@(posedge clk) disable iff (!rst_n)
        exc_cpu |-> (!wb_en && !$rose(quiesced)));

    // R9
    spec_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_spec && !retire_stall) |=> (!exc_cpu && !wb_en));
endmodule

bind thread_quiesce_ctrl qc_chk #(.NTHR(NTHR), .RIDX(RIDX)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_spec     (req_spec),
    .fetch_en     (fetch_en),
    .ext_fetch_en (ext_fetch_en),
    .eff_irq_en   (eff_irq_en),
    .thr_ie       (thr_ie),
    .wake         (wake),
    .thr_wait     (thr_wait),
    .thr_pause    (thr_pause),
    .retire_stall (retire_stall),
    .wb_en        (wb_en),
    .wb_idx       (wb_idx),
    .exc_cpu      (exc_cpu),
    .quiesced     (quiesced)
);

// File: tb/sim_thread_quiesce_ctrl.sv
// Self-checking bench: sweeps issuer and busy pattern, then the corner cases.
module sim_thread_quiesce_ctrl;
    localparam int NTHR = 4;
    localparam int TIDW = 2;
    localparam int RIDX = 5;
    localparam int XLEN = 64;
    localparam logic [NTHR-1:0] ALL = '1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_mt_en = 1'b1;
    logic req_valid = 1'b0, req_op = 1'b0;
    logic [TIDW-1:0] req_tid = '0;
    logic [RIDX-1:0] req_dst = '0;
    logic req_cp0_ok = 1'b1, req_spec = 1'b0, req_oldest = 1'b1;
    logic [NTHR-1:0] thr_busy = '0, thr_wait = '0, thr_pause = '0, thr_link = '0;
    logic [NTHR-1:0] thr_irq = '0, thr_ie = ALL, ext_fetch_en = ALL;
    logic [NTHR-1:0] fetch_en, eff_irq_en, wake, kill_spec;
    logic retire_stall, wb_en, exc_cpu, quiesced;
    logic [RIDX-1:0] wb_idx;
    logic [XLEN-1:0] wb_data;
    logic stall_at_accept;

    int checks = 0;
    int fails = 0;

    always #5 clk = ~clk;

    thread_quiesce_ctrl #(.NTHR(NTHR), .RIDX(RIDX), .XLEN(XLEN)) u0 (.*);

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    // Present one request for one cycle; return half a cycle after the edge.
    task automatic send(input logic op, input int tid, input int dst);
        @(negedge clk);
        req_valid = 1'b1; req_op = op;
        req_tid = TIDW'(tid); req_dst = RIDX'(dst);
        #1 stall_at_accept = retire_stall;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    function automatic logic [NTHR-1:0] others_of(input int tid);
        return ALL & ~(NTHR'(1) << tid);
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(fetch_en == ALL && !quiesced && !retire_stall && !wb_en && !exc_cpu,
            "reset state", {fetch_en, quiesced, retire_stall}, {ALL, 2'b00});

        // Sweep every issuer and every drain length.
        for (int t = 0; t < NTHR; t++) begin
            for (int d = 0; d < 4; d++) begin
                thr_busy = ALL;
                send(1'b0, t, t + 3);
                chk(stall_at_accept, "R2 stall in accept cycle", stall_at_accept, 1);
                chk(fetch_en == ~others_of(t), "R1 others stop fetching", fetch_en, ~others_of(t));
                chk(kill_spec == others_of(t), "R1 cancel pulse", kill_spec, others_of(t));
                chk(eff_irq_en == ~others_of(t), "R7 held irq masked", eff_irq_en, ~others_of(t));
                for (int k = 0; k < d; k++) begin
                    @(negedge clk);
                    chk(retire_stall && !quiesced && !wb_en, "R2 stall while busy",
                        {retire_stall, quiesced}, 2'b10);
                end
                chk(kill_spec == '0 || d == 0, "R1 cancel one cycle", kill_spec, 0);
                thr_busy = NTHR'(1) << t;   // issuer stays busy: must be ignored
                @(negedge clk);
                chk(quiesced && !retire_stall, "R2 flag after drain", {quiesced, retire_stall}, 2'b10);
                chk(wb_en && wb_idx == RIDX'(t + 3) && wb_data == '0, "R3 write-back",
                    {wb_en, wb_idx, wb_data[7:0]}, {1'b1, RIDX'(t + 3), 8'h00});
                @(negedge clk);
                chk(!wb_en, "R3 write-back one cycle", wb_en, 0);
                thr_busy = '0;
                send(1'b1, (t + 1) % NTHR, 0);
                chk(!quiesced && fetch_en == ALL, "R5 release", {quiesced, fetch_en}, {1'b0, ALL});
            end
        end

        // Destination 0: no write-back.
        send(1'b0, 1, 0);
        @(negedge clk);
        chk(quiesced && !wb_en, "R3 no write-back to index 0", {quiesced, wb_en}, 2'b10);

        // Nested quiesce while quiesced: nothing moves.
        send(1'b0, 2, 7);
        chk(!stall_at_accept && kill_spec == '0 && fetch_en == ~others_of(1),
            "R4 nested no-op", {stall_at_accept, fetch_en}, {1'b0, ~others_of(1)});
        @(negedge clk);
        chk(!wb_en && quiesced, "R4 nested no write-back", wb_en, 0);

        // External enable rises on a held thread: still no fetch.
        ext_fetch_en = ALL & ~NTHR'(4);
        @(negedge clk);
        chk(fetch_en == NTHR'(2), "R6 held ignores external", fetch_en, NTHR'(2));
        ext_fetch_en = ALL;
        @(negedge clk);
        chk(fetch_en == NTHR'(2), "R6 held ignores external rise", fetch_en, NTHR'(2));
        ext_fetch_en = ALL & ~NTHR'(4);
        send(1'b1, 1, 0);
        chk(fetch_en == (ALL & ~NTHR'(4)), "R6 release keeps external off", fetch_en, ALL & ~NTHR'(4));
        ext_fetch_en = ALL;

        // WAIT thread: interrupt during hold does not wake it.
        thr_wait = NTHR'(2); thr_irq = NTHR'(2);
        send(1'b0, 0, 0);
        @(negedge clk);
        chk(wake == '0, "R8 wait held ignores irq", wake, 0);
        send(1'b1, 0, 0);
        chk(wake == NTHR'(2), "R8 wait wakes after release", wake, NTHR'(2));
        // Release before interrupt: keeps waiting.
        thr_irq = '0;
        send(1'b0, 0, 0);
        @(negedge clk);
        send(1'b1, 0, 0);
        chk(wake == '0, "R8 wait still waiting", wake, 0);
        thr_irq = NTHR'(2);
        #1 chk(wake == NTHR'(2), "R8 wait wakes on irq", wake, NTHR'(2));
        thr_wait = '0; thr_irq = '0;

        // PAUSE thread: link clears during hold, no wake until release.
        thr_pause = NTHR'(4); thr_link = NTHR'(4);
        send(1'b0, 0, 0);
        thr_link = '0;
        @(negedge clk);
        chk(wake == '0, "R8 pause held ignores link clear", wake, 0);
        send(1'b1, 0, 0);
        chk(wake == NTHR'(4), "R8 pause wakes after release", wake, NTHR'(4));
        thr_pause = '0;

        // Speculative and non-oldest requests do nothing.
        req_spec = 1'b1; req_cp0_ok = 1'b0;
        send(1'b0, 0, 5);
        chk(!exc_cpu && fetch_en == ALL && !stall_at_accept, "R9 speculative ignored",
            {exc_cpu, fetch_en}, {1'b0, ALL});
        req_spec = 1'b0; req_oldest = 1'b0;
        send(1'b0, 0, 5);
        chk(!exc_cpu && fetch_en == ALL, "R9 not oldest ignored", {exc_cpu, fetch_en}, {1'b0, ALL});
        req_oldest = 1'b1;

        // No coprocessor access: exception only.
        send(1'b0, 0, 5);
        chk(exc_cpu && fetch_en == ALL && !quiesced, "R10 exception only",
            {exc_cpu, fetch_en, quiesced}, {1'b1, ALL, 1'b0});
        @(negedge clk);
        chk(!exc_cpu && !wb_en, "R10 exception one cycle", exc_cpu, 0);
        req_cp0_ok = 1'b1;

        // Multithreading off: no-op.
        cfg_mt_en = 1'b0;
        send(1'b0, 0, 5);
        @(negedge clk);
        chk(fetch_en == ALL && !quiesced && !wb_en && !exc_cpu, "R11 mt off no-op",
            {fetch_en, quiesced}, {ALL, 1'b0});
        cfg_mt_en = 1'b1;

        // Request during drain is ignored.
        thr_busy = ALL;
        send(1'b0, 0, 0);
        send(1'b1, 3, 0);
        chk(retire_stall && fetch_en == NTHR'(1), "R9 release during drain ignored",
            fetch_en, NTHR'(1));
        thr_busy = '0;
        @(negedge clk);
        chk(quiesced, "R2 drain completes", quiesced, 1);

        finish_run();
    end
endmodule